// File: doc/BRIEF.md
# Nonvolatile Array Program/Erase Sequencer

This block turns bus writes into timed program and erase operations for an on-chip nonvolatile array. Software first sets a clock divider that makes a slow timing enable from the bus clock. Each operation then starts with a write into the array address space, which latches an address and a data byte. A write to the command register launches the operation. The block counts timing enables for the length the operation needs. While it counts, it drives a program or erase strobe, the latched address and data, and the page or whole-array select to the external array interface.

Status comes out on plain pins: busy, done and access error. The error flag records any sequence that breaks the rules, and software clears it by writing 1 to a status register bit. While a byte program is running, one more byte program to the same page can be queued. When it starts back to back with the first, it runs with a shorter per-byte time.

The bus write port uses valid/ready. `wr_ready` is held high, so the block never applies back-pressure and accepts a write in every cycle in which `wr_valid` is high. Control and status pins carry no handshake.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command write before the divider register has been written after reset sets `acc_err` and starts nothing (`busy` stays 0).
- R2: The divider register (register offset 0, `wr_region`=0) takes only the first accepted write after reset; later writes leave the timing unchanged.
- R3: A divider write while `acc_err` is 1 is ignored and does not count as the one accepted write.
- R4: The divider byte holds the divide value in bits 5:0 and a prescale bit in bit 6. `timing_tick` pulses once every (div+1) bus cycles, or every 8*(div+1) cycles when the prescale bit is 1, and only while `busy` is high.
- R5: A write with `wr_region`=1 latches its address and data. A program command drives that address on `arr_addr` and that data on `arr_data` while `prog_en` is high. A command with no latched write sets `acc_err`.
- R6: Command codes are 0x11 blank check, 0x12 byte program, 0x13 burst byte program, 0x14 page erase and 0x15 whole-array erase (register offset 1). `busy` stays high for exactly N timing periods, with N = 1, 9, 9, 4000 and 20000 respectively. Blank check raises no strobe.
- R7: A burst command queued while a byte program is running, with a second latched write in the same 512-byte page, runs straight after the first and takes 4 periods. If the queued write is in another page, `acc_err` is set and the running command aborts. A burst command launched from idle takes 9 periods.
- R8: During a page erase, `arr_addr` is the latched address with its low 9 bits cleared and `page_sel` is 1. During a whole-array erase, `arr_addr` is 0 and `mass_sel` is 1. `arr_data` is 0 during erases, and `prog_en` and `erase_en` are never high together.
- R9: An array write while `busy` is high and no queue slot is free sets `acc_err`. The running command aborts, and `busy` and the strobes are low in the next cycle.
- R10: Writing a byte with bit 0 set to the status register (offset 2) clears `acc_err`. Writing bit 0 as 0 leaves it unchanged.
- R11: `busy`, `done` and `acc_err` are 0 after reset. `done` becomes 1 when a command ends normally and clears when the next command launches.
- R12: Command writes are ignored while `acc_err` is 1.
- R13: A command code outside the five listed values sets `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Bus write valid |
| wr_ready | output | 1 | Bus write ready, held high |
| wr_region | input | 1 | 1 = array space, 0 = register space |
| wr_addr | input | ADDR_W | Array byte address, or register offset in bits 1:0 |
| wr_data | input | DATA_W | Write data |
| busy | output | 1 | A command is running |
| done | output | 1 | The last command ended normally |
| acc_err | output | 1 | Access error pending |
| timing_tick | output | 1 | Single-cycle timing enable |
| prog_en | output | 1 | Program strobe to the array |
| erase_en | output | 1 | Erase strobe to the array |
| page_sel | output | 1 | Page erase select |
| mass_sel | output | 1 | Whole-array erase select |
| arr_addr | output | ADDR_W | Address to the array |
| arr_data | output | DATA_W | Program data to the array |

## Verification
An error in the divide or duration counter shows as a `busy` pulse that is longer or shorter by whole timing periods. It also shows as a `timing_tick` that arrives at the wrong cycle, visible at the first tick of the command. A lost or stale latch, or a wrong queue state, appears on `arr_addr`/`arr_data` during the first strobe cycle, or as a missing shortened burst when the first program ends. A wrong error or lock state is visible within one cycle on `acc_err`, or when a later command launches or is refused. The bench model predicts every output each cycle, so any such divergence is reported in the cycle where it first appears.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_BLANK = 3'd1,
    OP_PROG  = 3'd2,
    OP_BURST = 3'd3,
    OP_PAGE  = 3'd4,
    OP_MASS  = 3'd5
  } op_e;

  localparam logic [1:0] REG_DIV  = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  localparam logic [7:0] CODE_BLANK = 8'h11;
  localparam logic [7:0] CODE_PROG  = 8'h12;
  localparam logic [7:0] CODE_BURST = 8'h13;
  localparam logic [7:0] CODE_PAGE  = 8'h14;
  localparam logic [7:0] CODE_MASS  = 8'h15;

  function automatic op_e decode_cmd(input logic [7:0] code);
    case (code)
      CODE_BLANK: return OP_BLANK;
      CODE_PROG:  return OP_PROG;
      CODE_BURST: return OP_BURST;
      CODE_PAGE:  return OP_PAGE;
      CODE_MASS:  return OP_MASS;
      default:    return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fcs_prescaler.sv
module fcs_prescaler #(
  parameter int DIV_W    = 6,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic             pre,
  output logic             tick
);
  localparam int PC_W = DIV_W + $clog2(PRESCALE) + 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] lim;
  logic            at_end;

  always_comb begin
    if (pre) lim = (PC_W'(div) + PC_W'(1)) * PC_W'(PRESCALE);
    else     lim = PC_W'(div) + PC_W'(1);
  end

  assign at_end = (pc == lim - PC_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (restart) pc <= '0;
    else if (run)     pc <= at_end ? '0 : pc + PC_W'(1);
  end
endmodule

// File: rtl/fcs_duration.sv
module fcs_duration #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             final_tick
);
  logic [CNT_W-1:0] left;

  assign final_tick = tick && (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    left <= '0;
    else if (load)                 left <= load_val;
    else if (tick && left != '0)   left <= left - CNT_W'(1);
  end
endmodule

// File: rtl/fcs_outmap.sv
module fcs_outmap
  import fcs_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int PAGE_LSB = 9
) (
  input  logic              busy,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              prog_en,
  output logic              erase_en,
  output logic              page_sel,
  output logic              mass_sel,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  logic is_prog;

  assign is_prog  = busy && (op == OP_PROG || op == OP_BURST);
  assign prog_en  = is_prog;
  assign page_sel = busy && (op == OP_PAGE);
  assign mass_sel = busy && (op == OP_MASS);
  assign erase_en = page_sel || mass_sel;
  assign arr_data = is_prog ? data : '0;

  always_comb begin
    if (!busy || mass_sel) arr_addr = '0;
    else if (page_sel)     arr_addr = {addr[ADDR_W-1:PAGE_LSB], PAGE_LSB'(0)};
    else                   arr_addr = addr;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 512,
  parameter int DIV_W      = 6,
  parameter int PRESCALE   = 8,
  parameter int T_BLANK    = 1,
  parameter int T_PROG     = 9,
  parameter int T_BURST    = 4,
  parameter int T_PAGE     = 4000,
  parameter int T_MASS     = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_region,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              acc_err,
  output logic              timing_tick,
  output logic              prog_en,
  output logic              erase_en,
  output logic              page_sel,
  output logic              mass_sel,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int CNT_W    = $clog2(T_MASS + 1);

  logic              div_locked, pre_sel;
  logic [DIV_W-1:0]  div_val;
  logic              err_q, done_q, busy_q, queued_q, lat_v;
  logic [ADDR_W-1:0] lat_a, cur_a;
  logic [DATA_W-1:0] lat_d, cur_d;
  op_e               cur_op, cmd_op, start_op;

  logic wr_arr, is_div, is_cmd, is_stat;
  logic cur_is_prog, same_page, arr_ok_busy, queue_ok, cmd_ok;
  logic launch, bad_launch, bad_arr, bad_cmd, abort, set_err;
  logic fin, chain, start;
  logic [CNT_W-1:0] load_val;

  assign wr_ready = 1'b1;
  assign wr_arr   = wr_valid && wr_region;
  assign is_div   = wr_valid && !wr_region && wr_addr[1:0] == REG_DIV;
  assign is_cmd   = wr_valid && !wr_region && wr_addr[1:0] == REG_CMD;
  assign is_stat  = wr_valid && !wr_region && wr_addr[1:0] == REG_STAT;
  assign cmd_op   = decode_cmd(8'(wr_data));

  assign cur_is_prog = cur_op == OP_PROG || cur_op == OP_BURST;
  assign same_page   = lat_a[ADDR_W-1:PAGE_LSB] == cur_a[ADDR_W-1:PAGE_LSB];
  assign arr_ok_busy = cur_is_prog && !lat_v;
  assign queue_ok    = cmd_op == OP_BURST && lat_v && cur_is_prog && same_page && !queued_q;
  assign cmd_ok      = div_locked && lat_v && cmd_op != OP_NONE;

  assign launch     = is_cmd && !err_q && !busy_q && cmd_ok;
  assign bad_launch = is_cmd && !err_q && !busy_q && !cmd_ok;
  assign bad_arr    = wr_arr && busy_q && !arr_ok_busy;
  assign bad_cmd    = is_cmd && !err_q && busy_q && !queue_ok;
  assign abort      = bad_arr || bad_cmd;
  assign set_err    = bad_launch || abort;

  assign chain    = fin && queued_q && !abort;
  assign start    = launch || chain;
  assign start_op = launch ? cmd_op : OP_BURST;

  always_comb begin
    case (start_op)
      OP_BLANK: load_val = CNT_W'(T_BLANK);
      OP_BURST: load_val = chain ? CNT_W'(T_BURST) : CNT_W'(T_PROG);
      OP_PAGE:  load_val = CNT_W'(T_PAGE);
      OP_MASS:  load_val = CNT_W'(T_MASS);
      default:  load_val = CNT_W'(T_PROG);
    endcase
  end

  fcs_prescaler #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .restart(start),
    .div(div_val), .pre(pre_sel), .tick(timing_tick)
  );

  fcs_duration #(.CNT_W(CNT_W)) u_dur (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(load_val),
    .tick(timing_tick), .final_tick(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_locked <= 1'b0;
      div_val    <= '0;
      pre_sel    <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      busy_q     <= 1'b0;
      queued_q   <= 1'b0;
      lat_v      <= 1'b0;
      lat_a      <= '0;
      lat_d      <= '0;
      cur_a      <= '0;
      cur_d      <= '0;
      cur_op     <= OP_NONE;
    end else begin
      // error flag: write-one-to-clear, a new error in the same cycle wins
      if (is_stat && wr_data[0]) err_q <= 1'b0;
      if (set_err)               err_q <= 1'b1;

      // divider: first write only, and never while an error is pending
      if (is_div && !div_locked && !err_q) begin
        div_locked <= 1'b1;
        div_val    <= wr_data[DIV_W-1:0];
        pre_sel    <= wr_data[DIV_W];
      end

      // array write latch (idle, or one slot behind a running program)
      if (wr_arr && (!busy_q || arr_ok_busy)) begin
        lat_v <= 1'b1;
        lat_a <= wr_addr;
        lat_d <= wr_data;
      end
      if (start || abort || bad_launch) lat_v <= 1'b0;

      if (is_cmd && busy_q && !err_q && queue_ok) queued_q <= 1'b1;
      if (chain || abort)                          queued_q <= 1'b0;

      if (start) begin
        cur_op <= start_op;
        cur_a  <= lat_a;
        cur_d  <= lat_d;
      end

      if (abort)      busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (fin)   busy_q <= 1'b0;

      if (launch)                          done_q <= 1'b0;
      else if (fin && !queued_q && !abort) done_q <= 1'b1;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign acc_err = err_q;

  fcs_outmap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB)) u_map (
    .busy(busy_q), .op(cur_op), .addr(cur_a), .data(cur_d),
    .prog_en(prog_en), .erase_en(erase_en), .page_sel(page_sel),
    .mass_sel(mass_sel), .arr_addr(arr_addr), .arr_data(arr_data)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W   = 14,
  parameter int PAGE_LSB = 9,
  parameter int DIV_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              acc_err,
  input logic              timing_tick,
  input logic              prog_en,
  input logic              erase_en,
  input logic              page_sel,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              div_locked,
  input logic [DIV_W-1:0]  div_val,
  input logic              pre_sel
);
  assert_launch_needs_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> div_locked);

  assert_div_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_locked && $past(div_locked)) |-> ($stable(div_val) && $stable(pre_sel)));

  assert_tick_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_tick |-> busy);

  assert_strobe_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en || erase_en) |-> busy);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en));

  assert_page_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel |-> (arr_addr[PAGE_LSB-1:0] == '0));

  assert_end_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || acc_err));
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .acc_err(acc_err),
  .timing_tick(timing_tick), .prog_en(prog_en), .erase_en(erase_en),
  .page_sel(page_sel), .arr_addr(arr_addr), .div_locked(div_locked),
  .div_val(div_val), .pre_sel(pre_sel)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int AW = 14;
  localparam int DW = 8;
  localparam int OP_BLANK = 1, OP_PROG = 2, OP_BURST = 3, OP_PAGE = 4, OP_MASS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_region = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, busy, done, acc_err, timing_tick, prog_en, erase_en, page_sel, mass_sel;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_region(wr_region), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .acc_err(acc_err), .timing_tick(timing_tick),
    .prog_en(prog_en), .erase_en(erase_en), .page_sel(page_sel), .mass_sel(mass_sel),
    .arr_addr(arr_addr), .arr_data(arr_data)
  );

  // ---------------- behavioural reference model ----------------
  bit m_dset, m_err, m_done, m_busy, m_lv, m_q;
  int m_lim, m_el, m_rem, m_op, m_addr, m_data, m_la, m_ld;

  function automatic int dur_of(input int op);
    case (op)
      OP_BLANK: return 1;
      OP_PAGE:  return 4000;
      OP_MASS:  return 20000;
      default:  return 9;
    endcase
  endfunction

  function automatic int code_op(input int code);
    if (code >= 8'h11 && code <= 8'h15) return code - 8'h10;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dset = 0; m_err = 0; m_done = 0; m_busy = 0; m_lv = 0; m_q = 0;
      m_lim = 1; m_el = 0; m_rem = 0; m_op = 0; m_addr = 0; m_data = 0; m_la = 0; m_ld = 0;
    end else begin
      bit fin;
      int op;
      fin = m_busy && (m_rem == 1);
      if (m_busy) begin m_el++; m_rem--; end
      if (fin) begin
        if (m_q) begin
          m_op = OP_BURST; m_addr = m_la; m_data = m_ld; m_rem = 4 * m_lim;
          m_el = 0; m_q = 0; m_lv = 0;
        end else begin
          m_busy = 0; m_done = 1;
        end
      end else if (wr_valid) begin
        if (wr_region) begin
          if (!m_busy || ((m_op == OP_PROG || m_op == OP_BURST) && !m_lv)) begin
            m_lv = 1; m_la = int'(wr_addr); m_ld = int'(wr_data);
          end else begin
            m_err = 1; m_busy = 0; m_q = 0; m_lv = 0;
          end
        end else begin
          case (wr_addr[1:0])
            2'd0: if (!m_dset && !m_err) begin
                    m_dset = 1;
                    m_lim = (int'(wr_data[5:0]) + 1) * (wr_data[6] ? 8 : 1);
                  end
            2'd1: if (!m_err) begin
                    op = code_op(int'(wr_data));
                    if (!m_busy) begin
                      if (m_dset && m_lv && op != 0) begin
                        m_busy = 1; m_op = op; m_addr = m_la; m_data = m_ld; m_lv = 0;
                        m_done = 0; m_el = 0; m_rem = dur_of(op) * m_lim;
                      end else begin
                        m_err = 1; m_lv = 0;
                      end
                    end else if (op == OP_BURST && m_lv && (m_op == OP_PROG || m_op == OP_BURST)
                                 && (m_la / 512 == m_addr / 512) && !m_q) begin
                      m_q = 1;
                    end else begin
                      m_err = 1; m_busy = 0; m_q = 0; m_lv = 0;
                    end
                  end
            2'd2: if (wr_data[0]) m_err = 0;
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit pe, ee;
      int ea;
      pe = m_busy && (m_op == OP_PROG || m_op == OP_BURST);
      ee = m_busy && (m_op == OP_PAGE || m_op == OP_MASS);
      if (!m_busy || m_op == OP_MASS) ea = 0;
      else if (m_op == OP_PAGE)       ea = m_addr & ~511;
      else                            ea = m_addr;
      chk("R6 busy", int'(busy), int'(m_busy));
      chk("R11 done", int'(done), int'(m_done));
      chk("R5 acc_err", int'(acc_err), int'(m_err));
      chk("R4 timing_tick", int'(timing_tick), int'(m_busy && (m_el % m_lim == m_lim - 1)));
      chk("R5 prog_en", int'(prog_en), int'(pe));
      chk("R8 erase_en", int'(erase_en), int'(ee));
      chk("R8 page_sel", int'(page_sel), int'(m_busy && m_op == OP_PAGE));
      chk("R8 mass_sel", int'(mass_sel), int'(m_busy && m_op == OP_MASS));
      chk("R8 arr_addr", int'(arr_addr), ea);
      chk("R5 arr_data", int'(arr_data), pe ? m_data : 0);
      chk("wr_ready", int'(wr_ready), 1);
    end
  end

  // directed measurement of busy length and tick count
  int cur_len = 0, last_len = 0, cur_ticks = 0, last_ticks = 0;
  int cap_addr = -1, cap_data = -1;
  always @(negedge clk) begin
    if (busy) begin
      cur_len++;
      if (timing_tick) cur_ticks++;
      if ((prog_en || erase_en) && cap_addr < 0) begin
        cap_addr = int'(arr_addr); cap_data = int'(arr_data);
      end
    end else if (cur_len != 0) begin
      last_len = cur_len; last_ticks = cur_ticks; cur_len = 0; cur_ticks = 0;
    end
  end

  task automatic bus_wr(input bit region, input int addr, input int data);
    @(negedge clk); #1;
    wr_valid = 1; wr_region = region; wr_addr = AW'(addr); wr_data = DW'(data);
    @(negedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (busy);
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0;
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    @(negedge clk); #1;
  endtask

  initial begin
    do_reset();
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset acc_err", int'(acc_err), 0);

    // R1: command before divider
    bus_wr(1, 16'h10, 8'h55);
    bus_wr(0, 1, 8'h12);
    chk("R1 err no divider", int'(acc_err), 1);
    chk("R1 no launch", int'(busy), 0);

    // R3: divider refused while error pending; R10 clear rules
    bus_wr(0, 0, 8'h01);
    bus_wr(0, 2, 8'h00);
    chk("R10 write 0 keeps err", int'(acc_err), 1);
    bus_wr(0, 2, 8'h01);
    chk("R10 write 1 clears err", int'(acc_err), 0);
    bus_wr(1, 16'h10, 8'h55);
    bus_wr(0, 1, 8'h12);
    chk("R3 divider write was ignored", int'(acc_err), 1);
    chk("R3 still no launch", int'(busy), 0);
    bus_wr(0, 2, 8'h01);

    // R2: first write locks limit=2, second ignored
    bus_wr(0, 0, 8'h01);
    bus_wr(0, 0, 8'h05);

    // R5: launch without latch
    bus_wr(0, 1, 8'h12);
    chk("R5 no latch err", int'(acc_err), 1);
    bus_wr(0, 2, 8'h01);

    // R5/R6/R2: byte program
    cap_addr = -1;
    bus_wr(1, 16'h123, 8'hA5);
    bus_wr(0, 1, 8'h12);
    wait_idle();
    chk("R2 R6 program length", last_len, 18);
    chk("R6 program ticks", last_ticks, 9);
    chk("R5 program addr", cap_addr, 16'h123);
    chk("R5 program data", cap_data, 8'hA5);
    chk("R11 done after program", int'(done), 1);

    // R8 page erase
    cap_addr = -1;
    bus_wr(1, 16'h3FF, 8'h77);
    bus_wr(0, 1, 8'h14);
    chk("R11 done cleared at launch", int'(done), 0);
    wait_idle();
    chk("R6 page erase length", last_len, 8000);
    chk("R8 page aligned addr", cap_addr, 16'h200);
    chk("R8 erase data zero", cap_data, 0);

    // R8 mass erase
    cap_addr = -1;
    bus_wr(1, 16'h1234, 8'h33);
    bus_wr(0, 1, 8'h15);
    wait_idle();
    chk("R6 mass erase length", last_len, 40000);
    chk("R8 mass addr", cap_addr, 0);

    // R6 blank check
    cap_addr = -1;
    bus_wr(1, 16'h5, 8'h0);
    bus_wr(0, 1, 8'h11);
    wait_idle();
    chk("R6 blank length", last_len, 2);
    chk("R6 blank no strobe", cap_addr, -1);

    // R7 burst queued in same page
    bus_wr(1, 16'h400, 8'h01);
    bus_wr(0, 1, 8'h12);
    bus_wr(1, 16'h401, 8'h02);
    bus_wr(0, 1, 8'h13);
    wait_idle();
    chk("R7 chained burst length", last_len, 26);
    chk("R7 chained ticks", last_ticks, 13);
    chk("R7 done after chain", int'(done), 1);

    // R7 queued burst in another page
    bus_wr(1, 16'h400, 8'h01);
    bus_wr(0, 1, 8'h12);
    bus_wr(1, 16'h600, 8'h02);
    bus_wr(0, 1, 8'h13);
    chk("R7 cross page err", int'(acc_err), 1);
    chk("R7 cross page abort", int'(busy), 0);
    bus_wr(0, 2, 8'h01);

    // R7 burst from idle
    bus_wr(1, 16'h42, 8'h09);
    bus_wr(0, 1, 8'h13);
    wait_idle();
    chk("R7 idle burst length", last_len, 18);

    // R9 array write during erase
    bus_wr(1, 16'h800, 8'h00);
    bus_wr(0, 1, 8'h14);
    bus_wr(1, 16'h801, 8'h00);
    chk("R9 err on busy write", int'(acc_err), 1);
    chk("R9 aborted", int'(busy), 0);
    chk("R9 strobe dropped", int'(erase_en), 0);

    // R12 command ignored while error pending
    bus_wr(1, 16'h20, 8'h44);
    bus_wr(0, 1, 8'h12);
    chk("R12 ignored busy", int'(busy), 0);
    bus_wr(0, 2, 8'h01);
    bus_wr(0, 1, 8'h12);
    chk("R12 latch kept, launch after clear", int'(busy), 1);
    wait_idle();

    // R13 invalid code
    bus_wr(1, 16'h20, 8'h44);
    bus_wr(0, 1, 8'h33);
    chk("R13 invalid code err", int'(acc_err), 1);

    // R4 prescale bit
    do_reset();
    bus_wr(0, 0, 8'h41);
    bus_wr(1, 16'h7, 8'h3C);
    bus_wr(0, 1, 8'h12);
    wait_idle();
    chk("R4 prescaled program length", last_len, 144);
    chk("R4 prescaled ticks", last_ticks, 9);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule